// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives one device clock from a parent clock by integer division and passes it through a gate. Software controls it with a small register set. An enable register holds the single gate bit for this clock. A divisor register holds the ratio field. A status register reports a busy flag while a new divisor is waiting to take effect. It also reports a sticky flag for rejected divisor writes. A fourth read address returns the ratio that the divider is using at that moment.

The output clock is a single flop clocked by the parent. A new ratio or gate setting is applied only at the end of an output period, so every pulse has full width. Two decode variants are available, chosen by the field width. The 5-bit variant is the default. The 6-bit variant adds an extended range in which the top field bit multiplies the low five bits by 64.

Top module: `gated_clk_div`

## Requirements
- R1: After reset the output is low, the gate bit reads 0, the divisor field reads 0, status reads 0, and the ratio read-back is 2**DIV_W (32 for the default).
- R2: A divisor field of 0 selects the largest ratio, 2**DIV_W (32 when DIV_W=5, 64 when DIV_W=6).
- R3: A field value from 2 up to the mask selects that ratio. A field value of 1 is raised to a ratio of 2. The active ratio is never below 2.
- R4: When DIV_W=6 and field bit 5 is set, the ratio is 64 times field bits 4:0, and a low part of 0 gives 64. When bit 5 is clear, R2 and R3 apply.
- R5: Status bits 4 and 3 both read 1 from the cycle after an accepted divisor write until the divisor is applied. At all other times they read 0.
- R6: An accepted divisor is applied at the end of the output period that is running when it is written. The ratio read-back (address 3) changes and busy clears on that same parent edge.
- R7: A divisor write made while busy is set is ignored: the divisor field keeps its value. The write sets status bit 0, and that bit stays set until software writes 1 to bit 0 of the status address (2).
- R8: The gate is bit EN_BIT (default 3) of the enable address (0). Writes store only that bit, reads return it in that position, and all other bits read 0. While the gate is 0 the output stays low.
- R9: A gate change takes effect only at an output period boundary. A pulse that is already high when the gate is closed completes its full width, and the first pulse after the gate opens has full width.
- R10: Within each period of ratio N, the output is high for the first floor(N/2) parent cycles and low for the remaining ceil(N/2) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Register write strobe, one parent cycle |
| cfg_waddr_i | input | 2 | Write address: 0 gate, 1 divisor, 2 status |
| cfg_wdata_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address: 0 gate, 1 divisor, 2 status, 3 active ratio |
| rd_data_o | output | DATA_W | Read data, combinational from rd_addr_i |
| clk_o | output | 1 | Divided and gated clock |

## Verification
Assertions check several rules on every cycle. Busy holds until a period boundary. The active ratio changes only when a pending divisor is applied. A rejected write leaves the field intact and raises the error flag. The ratio never drops below 2. The output rises and the internal gate changes only at count zero.

Some behaviour can be shown only by the bench's scenarios. These include the exact decoded ratios for each field pattern in both variants, the measured high and low widths for even and odd ratios, and the full-width pulse when the gate closes mid-pulse. The bench also checks the read-back of the gate bit position and the timing at which busy clears relative to the rising edge of the output.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ADDR_GATE  = 2'd0,
        ADDR_DIV   = 2'd1,
        ADDR_STAT  = 2'd2,
        ADDR_RATIO = 2'd3
    } clkdiv_addr_e;

    localparam int STAT_ERR_BIT  = 0;
    localparam int STAT_BUSY_LO  = 3;
    localparam int STAT_BUSY_HI  = 4;

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
    parameter int DIV_W   = 5,
    parameter int RATIO_W = 6
) (
    input  logic [DIV_W-1:0]   field_i,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam logic [RATIO_W-1:0] RATIO_MAX = RATIO_W'(2 ** DIV_W);

    logic [RATIO_W-1:0] raw;

    generate
        if (DIV_W == 6) begin : g_ext
            always_comb begin
                if (field_i[5]) raw = RATIO_W'({field_i[4:0], 6'b000000});
                else            raw = RATIO_W'(field_i);
            end
        end else begin : g_norm
            always_comb raw = RATIO_W'(field_i);
        end
    endgenerate

    always_comb begin
        if (raw == '0)                   ratio_o = RATIO_MAX;
        else if (raw == RATIO_W'(1))     ratio_o = RATIO_W'(2);
        else                             ratio_o = raw;
    end

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
    parameter int RATIO_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               gate_i,
    output logic               wrap_o,
    output logic               clk_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               gate;
        logic               out;
    } core_st_t;

    core_st_t s_d, s_q;
    logic [RATIO_W-1:0] hi_len;

    always_comb begin
        s_d    = s_q;
        hi_len = ratio_i >> 1;
        wrap_o = (s_q.cnt == ratio_i - RATIO_W'(1));
        if (wrap_o) begin
            s_d.cnt  = '0;
            s_d.gate = gate_i;
        end else begin
            s_d.cnt  = s_q.cnt + RATIO_W'(1);
        end
        s_d.out = s_d.gate && (s_d.cnt < hi_len);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign clk_o = s_q.out;

    assert_rise_at_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_o) |-> (s_q.cnt == '0));

    assert_gate_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.gate) |-> (s_q.cnt == '0));

endmodule

// File: rtl/gated_clk_div.sv
module gated_clk_div
    import clkdiv_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int EN_BIT = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_waddr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              clk_o
);
    localparam int RATIO_W = (DIV_W == 6) ? 11 : DIV_W + 1;
    localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(2 ** DIV_W);

    typedef struct packed {
        logic               en;
        logic [DIV_W-1:0]   div;
        logic               pend;
        logic               err;
        logic [RATIO_W-1:0] ratio;
    } top_st_t;

    top_st_t s_d, s_q;
    logic [RATIO_W-1:0] ratio_new;
    logic               wrap;
    logic               wr_div;
    logic [DATA_W-1:0]  stat_word;
    logic               unused_wdata;

    assign unused_wdata = ^cfg_wdata_i;

    clkdiv_decode #(.DIV_W(DIV_W), .RATIO_W(RATIO_W)) u_decode (
        .field_i (s_q.div),
        .ratio_o (ratio_new)
    );

    clkdiv_core #(.RATIO_W(RATIO_W)) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ratio_i (s_q.ratio),
        .gate_i  (s_q.en),
        .wrap_o  (wrap),
        .clk_o   (clk_o)
    );

    always_comb begin
        s_d    = s_q;
        wr_div = cfg_wr_i && (cfg_waddr_i == ADDR_DIV);
        if (cfg_wr_i && (cfg_waddr_i == ADDR_GATE))
            s_d.en = cfg_wdata_i[EN_BIT];
        if (cfg_wr_i && (cfg_waddr_i == ADDR_STAT) && cfg_wdata_i[STAT_ERR_BIT])
            s_d.err = 1'b0;
        if (s_q.pend && wrap) begin
            s_d.ratio = ratio_new;
            s_d.pend  = 1'b0;
        end
        if (wr_div) begin
            if (s_q.pend) begin
                s_d.err = 1'b1;
            end else begin
                s_d.div  = cfg_wdata_i[DIV_W-1:0];
                s_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.ratio <= RATIO_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        stat_word               = '0;
        stat_word[STAT_BUSY_HI] = s_q.pend;
        stat_word[STAT_BUSY_LO] = s_q.pend;
        stat_word[STAT_ERR_BIT] = s_q.err;
        rd_data_o               = '0;
        case (rd_addr_i)
            ADDR_GATE: rd_data_o[EN_BIT] = s_q.en;
            ADDR_DIV:  rd_data_o = DATA_W'(s_q.div);
            ADDR_STAT: rd_data_o = stat_word;
            default:   rd_data_o = DATA_W'(s_q.ratio);
        endcase
    end

    assert_busy_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.pend && !wrap) |=> s_q.pend);

    assert_ratio_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(s_q.pend && wrap) |=> $stable(s_q.ratio));

    assert_reject_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && (cfg_waddr_i == ADDR_DIV) && s_q.pend) |=> (s_q.err && $stable(s_q.div)));

    assert_ratio_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.ratio >= RATIO_W'(2));

endmodule

// File: tb/gated_clk_div_bench.sv
module gated_clk_div_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [1:0]  cfg_waddr_i = 2'd0;
    logic [31:0] cfg_wdata_i = 32'd0;
    logic [1:0]  rd_addr_i = 2'd0;
    logic [31:0] rd_data_o, rd_data_ext;
    logic        clk_o, clk_o_ext;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk_i = ~clk_i;

    gated_clk_div u_gated_clk_div (
        .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_waddr_i(cfg_waddr_i),
        .cfg_wdata_i(cfg_wdata_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .clk_o(clk_o)
    );

    gated_clk_div #(.DIV_W(6)) u_gated_clk_div_ext (
        .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_waddr_i(cfg_waddr_i),
        .cfg_wdata_i(cfg_wdata_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_ext), .clk_o(clk_o_ext)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_waddr_i = a;
        cfg_wdata_i = d;
        cfg_wr_i    = 1'b1;
        @(negedge clk_i);
        cfg_wr_i    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d, output int d_ext);
        rd_addr_i = a;
        #1;
        d     = int'(rd_data_o);
        d_ext = int'(rd_data_ext);
    endtask

    task automatic wait_idle();
        int s, se;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd2, s, se);
            if (((s & 32'h18) == 0) && ((se & 32'h18) == 0)) break;
            @(negedge clk_i);
        end
    endtask

    task automatic set_div(input logic [31:0] f);
        wait_idle();
        wr(2'd1, f);
        wait_idle();
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev;
        hi = 0;
        lo = 0;
        prev = clk_o;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_i);
            if (!prev && clk_o) break;
            prev = clk_o;
        end
        while (clk_o && hi < 5000) begin hi++; @(negedge clk_i); end
        while (!clk_o && lo < 5000) begin lo++; @(negedge clk_i); end
    endtask

    task automatic t_reset();
        int d, de, ones;
        rd(2'd0, d, de); chk("R1 gate reg", d, 0);
        rd(2'd1, d, de); chk("R1 div reg", d, 0);
        rd(2'd2, d, de); chk("R1 status", d, 0);
        rd(2'd3, d, de); chk("R1 ratio", d, 32); chk("R1 ext ratio", de, 64);
        ones = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk_i); if (clk_o) ones++; end
        chk("R1 output low", ones, 0);
    endtask

    task automatic t_gate_bits();
        int d, de, ones;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d, de); chk("R8 gate bit set", d, 8);
        wr(2'd0, 32'hFFFF_FFF7);
        rd(2'd0, d, de); chk("R8 gate bit clear", d, 0);
        ones = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk_i); if (clk_o) ones++; end
        chk("R8 closed gate keeps output low", ones, 0);
    endtask

    task automatic t_div_decode();
        int hi, lo, d, de;
        wr(2'd0, 32'h8);
        set_div(32'd8);
        rd(2'd3, d, de); chk("R3 ratio 8", d, 8);
        measure(hi, lo); chk("R10 high n=8", hi, 4); chk("R10 low n=8", lo, 4);
        set_div(32'd5);
        rd(2'd3, d, de); chk("R3 ratio 5", d, 5);
        measure(hi, lo); chk("R10 high n=5", hi, 2); chk("R10 low n=5", lo, 3);
        set_div(32'd1);
        rd(2'd3, d, de); chk("R3 field 1 gives 2", d, 2);
        measure(hi, lo); chk("R10 high n=2", hi, 1); chk("R10 low n=2", lo, 1);
        set_div(32'd0);
        rd(2'd3, d, de); chk("R2 zero gives 32", d, 32); chk("R2 ext zero gives 64", de, 64);
        measure(hi, lo); chk("R2 high n=32", hi, 16); chk("R2 low n=32", lo, 16);
    endtask

    task automatic t_busy();
        int d, de, n;
        wait_idle();
        rd(2'd2, d, de); chk("R5 idle status", d, 0);
        wr(2'd1, 32'd6);
        rd(2'd2, d, de); chk("R5 busy bits", d, 32'h18);
        rd(2'd3, d, de); chk("R6 old ratio kept", d, 32);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            rd(2'd2, d, de);
            if ((d & 32'h18) == 0) break;
            n++;
            @(negedge clk_i);
        end
        chk("R6 busy within one period", int'(n <= 32), 1);
        chk("R6 output rises at apply", int'(clk_o), 1);
        rd(2'd3, d, de); chk("R6 new ratio", d, 6);
    endtask

    task automatic t_reject();
        int d, de;
        wait_idle();
        wr(2'd1, 32'd10);
        wr(2'd1, 32'd12);
        rd(2'd1, d, de); chk("R7 field kept", d, 10);
        rd(2'd2, d, de); chk("R7 error and busy", d, 32'h19);
        wait_idle();
        rd(2'd3, d, de); chk("R7 first value applied", d, 10);
        rd(2'd2, d, de); chk("R7 error sticky", d, 1);
        wr(2'd2, 32'd1);
        rd(2'd2, d, de); chk("R7 error cleared", d, 0);
    endtask

    task automatic t_gate_sync();
        int hi, ones;
        logic prev;
        set_div(32'd8);
        prev = clk_o;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_i);
            if (!prev && clk_o) break;
            prev = clk_o;
        end
        cfg_waddr_i = 2'd0; cfg_wdata_i = 32'd0; cfg_wr_i = 1'b1;
        hi = 1;
        @(negedge clk_i);
        cfg_wr_i = 1'b0;
        while (clk_o && hi < 100) begin hi++; @(negedge clk_i); end
        chk("R9 closing pulse full width", hi, 4);
        ones = 0;
        for (int i = 0; i < 24; i++) begin @(negedge clk_i); if (clk_o) ones++; end
        chk("R9 closed after boundary", ones, 0);
        wr(2'd0, 32'h8);
        for (int i = 0; i < 20; i++) begin if (clk_o) break; @(negedge clk_i); end
        hi = 0;
        while (clk_o && hi < 100) begin hi++; @(negedge clk_i); end
        chk("R9 opening pulse full width", hi, 4);
    endtask

    task automatic t_ext();
        int d, de;
        set_div(32'h23);
        rd(2'd3, d, de); chk("R4 ext 0x23", de, 192); chk("R3 normal field 3", d, 3);
        set_div(32'h20);
        rd(2'd3, d, de); chk("R4 ext 0x20 gives 64", de, 64); chk("R2 normal masked zero", d, 32);
        set_div(32'h05);
        rd(2'd3, d, de); chk("R4 ext bit5 clear", de, 5);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk_i);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_gate_bits();
        t_div_decode();
        t_busy();
        t_reject();
        t_gate_sync();
        t_ext();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule